// File: doc/BRIEF.md
# Strap-Latched Configuration Register Bank

This block is the control and status register file of a four-lane, eight-channel serial signal conditioner. It has twelve byte addresses. A serial-bus slave front end, which is outside this block, reaches them through a plain byte write/read port. The analog channel circuits are also outside the block. They report per-channel signal presence and receiver presence as two live status vectors, and they take their settings from decoded control outputs.

Power-on reset does not use fixed constants for the loopback, channel-reset and detect-enable registers. While reset is held low, these registers follow four strap pins. When reset is released, they keep the strap values seen at the last clock edge. A level-sensitive lock input blocks every bus write for as long as it is high. Bytes 0 to 7 hold one bit per channel, and the lanes interleave their channels. The block also gives a one-cycle restart pulse for each channel whose reset bit is written from 0 to 1. A receiver-detect controller further down the chain uses this pulse.

Top module: `strap_cfg_bank`

## Requirements
- R1: When cfg_lock_i is high at a clock edge, a write at that edge changes no register. When it is low, a write is accepted. The lock is checked again at every edge and is never stored.
- R2: While rst_ni is low, the registers follow the straps. Byte 2 bits 7..4 equal strap_loop_ni. Every bit of byte 5 equals strap_chrst_ni. In byte 7, the A bits (7,5,3,1) equal strap_det_a_i and the B bits (6,4,2,0) equal strap_det_b_i. The values at the release of reset are kept.
- R3: In bytes 0 to 7, and in every 8-bit per-channel output, bit 7 is channel A0. The remaining bits run B0, A1, B1, A2, B2, A3, down to B3 in bit 0.
- R4: A read of byte 0 returns sig_det_i and a read of byte 1 returns rx_found_i, with no clock delay. Writes to bytes 0 and 1 have no effect.
- R5: Byte 2 holds the loopback-not bits in bits 7..4, with lane 0 in bit 7, driven on loop_n_o[3:0] with bit 7 on loop_n_o[3]. Bit 3 is the group A emphasis mode and bit 2 is the group B emphasis mode, where 1 means de-emphasis. They are driven on deemph_o[1] (A) and deemph_o[0] (B) and reset to 1. Bits 1..0 always read 0 and cannot be written.
- R6: Byte 3 (input disable) and byte 4 (output disable) reset to 0x00. Byte 6 (power-down-not) resets to 0xFF. They drive in_dis_o, out_dis_o and pwr_n_o.
- R7: Bytes 8 (group A) and 9 (group B) reset to 0xFF. Bits 7,6,5 are equalizer code bits 0,1,2. Bits 4,3,2 are emphasis code bits 0,1,2. Bits 1,0 are swing code bits 0,1.
- R8: Bytes 10 and 11 are fully read/write and reset to 0x00.
- R9: A write to address 12..15 is discarded, and a read from those addresses returns 0x00.
- R10: A write to byte 5 raises det_restart_o[i] for exactly one cycle for each bit i that goes from 0 to 1. A bit written 1 to 1, a bit written 1 to 0, and a write blocked by the lock give no pulse.
- R11: An accepted write shows on rdata_o and on the control outputs from the clock edge that takes it. The restart pulse appears at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| strap_loop_ni | input | 1 | Loopback-not strap |
| strap_chrst_ni | input | 1 | Channel-reset-not strap |
| strap_det_a_i | input | 1 | Group A detect-enable strap |
| strap_det_b_i | input | 1 | Group B detect-enable strap |
| cfg_lock_i | input | 1 | High blocks all writes |
| wr_en_i | input | 1 | Byte write strobe |
| addr_i | input | 4 | Byte address for read and write |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| sig_det_i | input | 8 | Live per-channel signal present |
| rx_found_i | input | 8 | Live per-channel receiver found |
| loop_n_o | output | 4 | Per-lane loopback-not |
| deemph_o | output | 2 | Emphasis mode, bit 1 group A, bit 0 group B |
| in_dis_o | output | 8 | Per-channel input disable |
| out_dis_o | output | 8 | Per-channel output disable |
| ch_rst_n_o | output | 8 | Per-channel reset-not |
| pwr_n_o | output | 8 | Per-channel power-down-not |
| det_en_o | output | 8 | Per-channel receiver-detect enable |
| eq_a_o | output | 3 | Group A equalizer code |
| emph_a_o | output | 3 | Group A emphasis code |
| swing_a_o | output | 2 | Group A swing code |
| eq_b_o | output | 3 | Group B equalizer code |
| emph_b_o | output | 3 | Group B emphasis code |
| swing_b_o | output | 2 | Group B swing code |
| det_restart_o | output | 8 | One-cycle detect restart per channel |

## Verification
Every register drives a port without delay, so a wrong stored bit shows in the next cycle. It appears on its decoded control output and on rdata_o whenever the reference model points addr_i at that byte. A write that slips past the lock, or a wrong strap capture, gives a mismatch at the first comparison after that edge. An error in the restart edge detector appears as a missing, extra or two-cycle det_restart_o bit in the cycle after the byte 5 write.

// File: rtl/strap_cfg_pkg.sv
package strap_cfg_pkg;
  localparam int LANES    = 4;
  localparam int CH       = 2 * LANES;
  localparam int BYTE_W   = 8;
  localparam int NUM_REGS = 12;
  localparam int ADDR_W   = 4;
  localparam int FIRST_RW = 2;

  localparam int A_SIG = 0;
  localparam int A_RXF = 1;
  localparam int A_LBE = 2;
  localparam int A_IND = 3;
  localparam int A_OUD = 4;
  localparam int A_CRS = 5;
  localparam int A_PWR = 6;
  localparam int A_DEN = 7;
  localparam int A_GRA = 8;
  localparam int A_GRB = 9;

  typedef struct packed {
    logic [2:0] eq;
    logic [2:0] emph;
    logic [1:0] swing;
  } grp_cfg_t;

  function automatic logic [BYTE_W-1:0] wmask(input int idx);
    if (idx == A_LBE) return 8'hFC;
    return 8'hFF;
  endfunction

  // field bit 0 sits at the higher register bit
  function automatic grp_cfg_t unpack_grp(input logic [BYTE_W-1:0] b);
    grp_cfg_t g;
    g.eq    = {b[5], b[6], b[7]};
    g.emph  = {b[2], b[3], b[4]};
    g.swing = {b[0], b[1]};
    return g;
  endfunction
endpackage

// File: rtl/scfg_wr_decode.sv
module scfg_wr_decode
  import strap_cfg_pkg::*;
(
  input  logic                         lock_i,
  input  logic                         we_i,
  input  logic [ADDR_W-1:0]            addr_i,
  output logic [NUM_REGS-1:FIRST_RW]   strobe_o
);
  for (genvar k = FIRST_RW; k < NUM_REGS; k++) begin : g_dec
    assign strobe_o[k] = we_i && !lock_i && (addr_i == ADDR_W'(k));
  end
endmodule

// File: rtl/scfg_byte_reg.sv
module scfg_byte_reg #(
  parameter int            W     = 8,
  parameter logic [W-1:0]  WMASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] rst_val_i,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= rst_val_i & WMASK;
    else if (we_i) q_o <= wdata_i & WMASK;
  end
endmodule

// File: rtl/scfg_rd_mux.sv
module scfg_rd_mux
  import strap_cfg_pkg::*;
(
  input  logic [ADDR_W-1:0]                      addr_i,
  input  logic [BYTE_W-1:0]                      sig_i,
  input  logic [BYTE_W-1:0]                      rxf_i,
  input  logic [NUM_REGS-1:FIRST_RW][BYTE_W-1:0] regs_i,
  output logic [BYTE_W-1:0]                      rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(A_SIG)) rdata_o = sig_i;
    if (addr_i == ADDR_W'(A_RXF)) rdata_o = rxf_i;
    for (int k = FIRST_RW; k < NUM_REGS; k++)
      if (addr_i == ADDR_W'(k)) rdata_o = regs_i[k];
  end
endmodule

// File: rtl/scfg_restart_pulse.sv
module scfg_restart_pulse
  import strap_cfg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [CH-1:0] wdata_i,
  input  logic [CH-1:0] cur_i,
  output logic [CH-1:0] pulse_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pulse_o <= '0;
    else if (we_i) pulse_o <= wdata_i & ~cur_i;
    else           pulse_o <= '0;
  end

  for (genvar i = 0; i < CH; i++) begin : g_chk
    assert_pulse_once_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pulse_o[i] |=> !pulse_o[i]);
    assert_pulse_level_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pulse_o[i] |-> cur_i[i]);
  end
endmodule

// File: rtl/strap_cfg_bank.sv
module strap_cfg_bank
  import strap_cfg_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          strap_loop_ni,
  input  logic          strap_chrst_ni,
  input  logic          strap_det_a_i,
  input  logic          strap_det_b_i,
  input  logic          cfg_lock_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o,
  input  logic [7:0]    sig_det_i,
  input  logic [7:0]    rx_found_i,
  output logic [3:0]    loop_n_o,
  output logic [1:0]    deemph_o,
  output logic [7:0]    in_dis_o,
  output logic [7:0]    out_dis_o,
  output logic [7:0]    ch_rst_n_o,
  output logic [7:0]    pwr_n_o,
  output logic [7:0]    det_en_o,
  output logic [2:0]    eq_a_o,
  output logic [2:0]    emph_a_o,
  output logic [1:0]    swing_a_o,
  output logic [2:0]    eq_b_o,
  output logic [2:0]    emph_b_o,
  output logic [1:0]    swing_b_o,
  output logic [7:0]    det_restart_o
);
  logic [NUM_REGS-1:FIRST_RW]             strobe;
  logic [NUM_REGS-1:FIRST_RW][BYTE_W-1:0] rst_val;
  logic [NUM_REGS-1:FIRST_RW][BYTE_W-1:0] regs_q;
  grp_cfg_t grp_a, grp_b;

  // strap-derived reset values; others fixed
  always_comb begin
    for (int k = FIRST_RW; k < NUM_REGS; k++) rst_val[k] = '0;
    rst_val[A_LBE] = {{LANES{strap_loop_ni}}, 2'b11, 2'b00};
    rst_val[A_CRS] = {CH{strap_chrst_ni}};
    rst_val[A_PWR] = '1;
    rst_val[A_DEN] = {LANES{strap_det_a_i, strap_det_b_i}};
    rst_val[A_GRA] = '1;
    rst_val[A_GRB] = '1;
  end

  scfg_wr_decode u_dec (
    .lock_i  (cfg_lock_i),
    .we_i    (wr_en_i),
    .addr_i  (addr_i),
    .strobe_o(strobe)
  );

  for (genvar k = FIRST_RW; k < NUM_REGS; k++) begin : g_reg
    scfg_byte_reg #(.W(BYTE_W), .WMASK(wmask(k))) u_reg (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .rst_val_i(rst_val[k]),
      .we_i     (strobe[k]),
      .wdata_i  (wdata_i),
      .q_o      (regs_q[k])
    );
  end

  scfg_rd_mux u_rd (
    .addr_i (addr_i),
    .sig_i  (sig_det_i),
    .rxf_i  (rx_found_i),
    .regs_i (regs_q),
    .rdata_o(rdata_o)
  );

  scfg_restart_pulse u_rst_pulse (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (strobe[A_CRS]),
    .wdata_i(wdata_i),
    .cur_i  (regs_q[A_CRS]),
    .pulse_o(det_restart_o)
  );

  assign grp_a      = unpack_grp(regs_q[A_GRA]);
  assign grp_b      = unpack_grp(regs_q[A_GRB]);
  assign loop_n_o   = regs_q[A_LBE][7:4];
  assign deemph_o   = regs_q[A_LBE][3:2];
  assign in_dis_o   = regs_q[A_IND];
  assign out_dis_o  = regs_q[A_OUD];
  assign ch_rst_n_o = regs_q[A_CRS];
  assign pwr_n_o    = regs_q[A_PWR];
  assign det_en_o   = regs_q[A_DEN];
  assign eq_a_o     = grp_a.eq;
  assign emph_a_o   = grp_a.emph;
  assign swing_a_o  = grp_a.swing;
  assign eq_b_o     = grp_b.eq;
  assign emph_b_o   = grp_b.emph;
  assign swing_b_o  = grp_b.swing;

  assert_lock_freeze_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_lock_i |=> $stable(regs_q));
  assert_hole_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i >= AW'(NUM_REGS)) |-> (rdata_o == 8'h00));
  assert_rsvd_bits_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == AW'(A_LBE)) |-> (rdata_o[1:0] == 2'b00));
  assert_live_sig_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == AW'(A_SIG)) |-> (rdata_o == sig_det_i));
  assert_strobe_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(strobe));
endmodule

// File: tb/sim_strap_cfg_bank.sv
module sim_strap_cfg_bank;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic s_loop = 1'b0, s_crs = 1'b1, s_da = 1'b1, s_db = 1'b0;
  logic lock = 1'b0, we = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wd = '0, sig = '0, rxf = '0;
  logic [7:0] rdata, in_dis, out_dis, ch_rst, pwr, det_en, restart;
  logic [3:0] loop_n;
  logic [1:0] deemph, sw_a, sw_b;
  logic [2:0] eq_a, em_a, eq_b, em_b;
  int errors = 0, checks = 0;
  logic [7:0] m [12];
  logic [7:0] m_pulse;

  always #5 clk = ~clk;

  strap_cfg_bank u0 (
    .clk_i(clk), .rst_ni(rst_ni), .strap_loop_ni(s_loop), .strap_chrst_ni(s_crs),
    .strap_det_a_i(s_da), .strap_det_b_i(s_db), .cfg_lock_i(lock), .wr_en_i(we),
    .addr_i(addr), .wdata_i(wd), .rdata_o(rdata), .sig_det_i(sig), .rx_found_i(rxf),
    .loop_n_o(loop_n), .deemph_o(deemph), .in_dis_o(in_dis), .out_dis_o(out_dis),
    .ch_rst_n_o(ch_rst), .pwr_n_o(pwr), .det_en_o(det_en), .eq_a_o(eq_a),
    .emph_a_o(em_a), .swing_a_o(sw_a), .eq_b_o(eq_b), .emph_b_o(em_b),
    .swing_b_o(sw_b), .det_restart_o(restart)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m[2]  <= {{4{s_loop}}, 4'b1100};
      m[3]  <= 8'h00;  m[4] <= 8'h00;
      m[5]  <= {8{s_crs}};
      m[6]  <= 8'hFF;
      m[7]  <= {4{s_da, s_db}};
      m[8]  <= 8'hFF;  m[9] <= 8'hFF;
      m[10] <= 8'h00;  m[11] <= 8'h00;
      m_pulse <= 8'h00;
    end else begin
      m_pulse <= (we && !lock && addr == 4'd5) ? (wd & ~m[5]) : 8'h00;
      if (we && !lock && addr >= 4'd2 && addr <= 4'd11)
        m[addr] <= (addr == 4'd2) ? {wd[7:2], 2'b00} : wd;
    end
  end

  function automatic logic [7:0] exp_rd(input logic [3:0] a);
    if (a == 4'd0) return sig;
    if (a == 4'd1) return rxf;
    if (a <= 4'd11) return m[a];
    return 8'h00;
  endfunction

  function automatic string rd_tag(input logic [3:0] a);
    if (a <= 4'd1) return "R4 rdata";
    if (a == 4'd2) return "R5 rdata";
    if (a == 4'd5 || a == 4'd7) return "R2 rdata";
    if (a <= 4'd6) return "R6 rdata";
    if (a <= 4'd9) return "R7 rdata";
    if (a <= 4'd11) return "R8 rdata";
    return "R9 rdata";
  endfunction

  always @(negedge clk) begin
    chk(rd_tag(addr), rdata, exp_rd(addr));
    chk("R5 loop_n", loop_n, m[2][7:4]);
    chk("R5 deemph", deemph, m[2][3:2]);
    chk("R6 in_dis", in_dis, m[3]);
    chk("R6 out_dis", out_dis, m[4]);
    chk("R2 ch_rst", ch_rst, m[5]);
    chk("R6 pwr", pwr, m[6]);
    chk("R2 det_en", det_en, m[7]);
    chk("R7 grpA", {eq_a, em_a, sw_a}, {m[8][5], m[8][6], m[8][7], m[8][2], m[8][3], m[8][4], m[8][0], m[8][1]});
    chk("R7 grpB", {eq_b, em_b, sw_b}, {m[9][5], m[9][6], m[9][7], m[9][2], m[9][3], m[9][4], m[9][0], m[9][1]});
    chk("R10 restart", restart, m_pulse);
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(posedge clk); #1 we = 1'b1; addr = a; wd = d;
    @(posedge clk); #1 we = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd_at(input logic [3:0] a);
    @(posedge clk); #1 addr = a;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    rd_at(4'd2);  chk("R2 loop strap", rdata, 8'h0C);
    rd_at(4'd5);  chk("R2 reset strap", rdata, 8'hFF);
    rd_at(4'd7);  chk("R2 detect straps", rdata, 8'hAA);
    rd_at(4'd6);  chk("R6 pwr reset", rdata, 8'hFF);
    rd_at(4'd8);  chk("R7 grpA reset", rdata, 8'hFF);
    rd_at(4'd10); chk("R8 spare reset", rdata, 8'h00);
    // R3 channel order
    #1 sig = 8'h80; rd_at(4'd0); chk("R3 sig A0 at bit7", rdata, 8'h80);
    wr(4'd3, 8'h40); chk("R3 in_dis B0", in_dis, 8'h40);
    // R4 status read-only
    wr(4'd0, 8'h3C); #1 sig = 8'h11; rxf = 8'h22;
    rd_at(4'd0); chk("R4 sig live", rdata, 8'h11);
    rd_at(4'd1); chk("R4 rxf live", rdata, 8'h22);
    // R1 lock
    #1 lock = 1'b1; wr(4'd10, 8'h5A);
    rd_at(4'd10); chk("R1 locked write", rdata, 8'h00);
    #1 lock = 1'b0; wr(4'd10, 8'h5A);
    chk("R11 write visible", rdata, 8'h5A);
    // R5 reserved bits
    wr(4'd2, 8'hFF); chk("R5 rsvd bits", rdata, 8'hFC);
    // R7 field decode
    wr(4'd8, 8'h8D);
    chk("R7 eq", eq_a, 3'b001); chk("R7 emph", em_a, 3'b110); chk("R7 swing", sw_a, 2'b10);
    // R9 hole
    wr(4'd12, 8'hAB); chk("R9 hole read", rdata, 8'h00);
    // R10 restart pulses
    wr(4'd5, 8'h00); chk("R10 no pulse on clear", restart, 8'h00);
    wr(4'd5, 8'h0F); chk("R10 rise pulse", restart, 8'h0F);
    @(negedge clk);  chk("R10 pulse ends", restart, 8'h00);
    wr(4'd5, 8'hFF); chk("R10 only new rises", restart, 8'hF0);
    #1 lock = 1'b1; wr(4'd5, 8'h00); #1 lock = 1'b0;
    // random phase with model compare every clock
    for (int n = 0; n < 4000; n++) begin
      @(posedge clk); #1;
      we = $urandom_range(0, 1) == 1;
      addr = 4'($urandom_range(0, 15));
      wd = 8'($urandom);
      lock = $urandom_range(0, 3) == 0;
      sig = 8'($urandom); rxf = 8'($urandom);
    end
    // second power-on with other straps
    @(posedge clk); #1 we = 1'b0; lock = 1'b0;
    rst_ni = 1'b0; s_loop = 1'b1; s_crs = 1'b0; s_da = 1'b0; s_db = 1'b1;
    repeat (2) @(posedge clk); #1 rst_ni = 1'b1;
    rd_at(4'd2); chk("R2 loop strap high", rdata, 8'hFC);
    rd_at(4'd5); chk("R2 reset strap low", rdata, 8'h00);
    rd_at(4'd7); chk("R2 detect B only", rdata, 8'h55);
    wr(4'd5, 8'h81); chk("R10 after strap low", restart, 8'h81);
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule